// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block is the digital side of an 8-pin general-purpose port. Each pin has a direction bit, a level register, and three software options: pull-up, pull-down and open-drain. The block drives output value and output enable per pin toward the pads, and it brings the pad input back through a synchronizer. It also emits enable signals for the pull resistors. The resistors and the analog pad sit outside the block.

Software uses a simple register bus. Each access completes in the cycle it is presented, so the bus has no valid/ready handshake and no back-pressure. A write lands on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. Reading the level register is the only read that has a side effect, and that side effect happens only when `bus_rd` is high at a clock edge.

The port also watches its input pins for change. It keeps a snapshot of the synchronized inputs, taken at the last level-register read. When any input pin differs from that snapshot, a sticky change flag is set. This flag serves as the interrupt or wake-up request, and the next level-register read clears it.

Top module: `bidir_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the pull-up, pull-down, open-drain and level registers read 0, `pad_oe`, `pull_up`, `pull_dn` are 0 and `chg_event` is 0.
- R2: Register addresses are: 0 level, 1 direction, 2 pull-up enable, 3 pull-down enable, 4 open-drain select. A write to 1..4 is read back unchanged from the edge after the write.
- R3: A pin whose direction bit is 0 and open-drain bit is 0 has `pad_oe`=1 and `pad_out` equal to its level-register bit.
- R4: A pin whose direction bit is 1 has `pad_oe`=0 regardless of other settings.
- R5: A pin with open-drain bit 1 has `pad_out`=0; if it is an output, `pad_oe` is the inverse of its level bit (level 1 releases the pin).
- R6: Reading address 0 returns, per pin, the synchronized pad level for inputs (visible 2 clock edges after the pad changes) and the level-register bit for outputs.
- R7: `pull_up` equals the pull-up register; `pull_dn` equals the pull-down register with every bit cleared where pull-up is also set.
- R8: `chg_event` rises one edge after a synchronized input pin differs from the snapshot (3 edges after the pad change) and stays high when the pin returns.
- R9: An edge with `bus_rd`=1 at address 0 clears `chg_event` and captures a new snapshot. Pad changes on output pins never set `chg_event`.
- R10: Addresses 5..7 read 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect only on level register) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable |
| pull_up | output | 8 | Per-pin pull-up enable |
| pull_dn | output | 8 | Per-pin pull-down enable |
| chg_event | output | 1 | Sticky input-change interrupt / wake-up request |

## Verification
A register write shows up at the pad controls and on readback after the write's own clock edge. The bench therefore samples on the following falling edge. A pad level takes two edges to reach level readback, and `chg_event` follows one edge after that. The bench drives pads on a falling edge and checks after exactly one edge, two edges and three edges. Each check confirms both the value still unchanged before its due cycle and the new value in that cycle. A clearing read is one strobed edge, and the bench checks the flag on the next falling edge.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEVEL  = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_PULLUP = 3'd2,
    SEL_PULLDN = 3'd3,
    SEL_ODRAIN = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/bidir_port_sync.sv
module bidir_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/bidir_port_regs.sv
module bidir_port_regs
  import bidir_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  level_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pu_q,
  output logic [WIDTH-1:0]  pd_q,
  output logic [WIDTH-1:0]  od_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '1;
      pu_q    <= '0;
      pd_q    <= '0;
      od_q    <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        SEL_LEVEL:  level_q <= wdata;
        SEL_DIR:    dir_q   <= wdata;
        SEL_PULLUP: pu_q    <= wdata;
        SEL_PULLDN: pd_q    <= wdata;
        SEL_ODRAIN: od_q    <= wdata;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/bidir_port_pad.sv
module bidir_port_pad #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] level_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pu_q,
  input  logic [WIDTH-1:0] pd_q,
  input  logic [WIDTH-1:0] od_q,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pull_up,
  output logic [WIDTH-1:0] pull_dn
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic drive_en;
    always_comb begin
      if (dir_q[i])      drive_en = 1'b0;
      else if (od_q[i])  drive_en = ~level_q[i];
      else               drive_en = 1'b1;
    end
    assign pad_oe[i]  = drive_en;
    assign pad_out[i] = od_q[i] ? 1'b0 : level_q[i];
    assign pull_up[i] = pu_q[i];
    assign pull_dn[i] = pd_q[i] & ~pu_q[i];
  end
endmodule

// File: rtl/bidir_port_change.sv
module bidir_port_change #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sampled,
  input  logic [WIDTH-1:0] dir_q,
  input  logic             snap_take,
  output logic             flag
);
  logic [WIDTH-1:0] snap_q;
  logic             mismatch;

  assign mismatch = |((sampled ^ snap_q) & dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag   <= 1'b0;
    end else if (snap_take) begin
      snap_q <= sampled;
      flag   <= 1'b0;
    end else if (mismatch) begin
      flag   <= 1'b1;
    end
  end
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bidir_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pull_up,
  output logic [WIDTH-1:0]  pull_dn,
  output logic              chg_event
);
  logic [WIDTH-1:0] level_q, dir_q, pu_q, pd_q, od_q;
  logic [WIDTH-1:0] in_sync;
  logic             level_read;

  bidir_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
  );

  bidir_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .level_q(level_q), .dir_q(dir_q),
    .pu_q(pu_q), .pd_q(pd_q), .od_q(od_q)
  );

  bidir_port_pad #(.WIDTH(WIDTH)) u_pad (
    .level_q(level_q), .dir_q(dir_q), .pu_q(pu_q), .pd_q(pd_q),
    .od_q(od_q), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn)
  );

  assign level_read = bus_rd && (reg_sel_e'(bus_addr) == SEL_LEVEL);

  bidir_port_change #(.WIDTH(WIDTH)) u_chg (
    .clk(clk), .rst_n(rst_n), .sampled(in_sync), .dir_q(dir_q),
    .snap_take(level_read), .flag(chg_event)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_LEVEL:  bus_rdata = (in_sync & dir_q) | (level_q & ~dir_q);
      SEL_DIR:    bus_rdata = dir_q;
      SEL_PULLUP: bus_rdata = pu_q;
      SEL_PULLDN: bus_rdata = pd_q;
      SEL_ODRAIN: bus_rdata = od_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bidir_port_chk.sv
module bidir_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [2:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pull_up,
  input logic [WIDTH-1:0] pull_dn,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] od_q,
  input logic             chg_event
);
  p_in_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);

  p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);

  p_pull_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0);

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> (dir_q == $past(bus_wdata)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_event && !(bus_rd && bus_addr == 3'd0)) |=> chg_event);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0) |=> !chg_event);

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 3'd4) |-> (bus_rdata == '0));
endmodule

bind bidir_port bidir_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up),
  .pull_dn(pull_dn), .dir_q(dir_q), .od_q(od_q), .chg_event(chg_event)
);

// File: tb/bidir_port_bench.sv
module bidir_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00, pad_in = 8'h00;
  logic [7:0] bus_rdata, pad_out, pad_oe, pull_up, pull_dn;
  logic       chg_event;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_port u_bidir_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .chg_event(chg_event)
  );

  typedef struct packed {
    logic [7:0] dir, od, lvl, pu, pd, e_oe, e_out, e_pu, e_pd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hFF, 8'h00, 8'h55, 8'h00, 8'h00, 8'h00, 8'h55, 8'h00, 8'h00},
    '{8'h00, 8'h00, 8'hA5, 8'hF0, 8'h0F, 8'hFF, 8'hA5, 8'hF0, 8'h0F},
    '{8'h00, 8'hFF, 8'h3C, 8'h00, 8'hFF, 8'hC3, 8'h00, 8'h00, 8'hFF},
    '{8'h0F, 8'h33, 8'h96, 8'hFF, 8'hFF, 8'hE0, 8'h84, 8'hFF, 8'h00},
    '{8'hF0, 8'h0F, 8'hFF, 8'h0A, 8'h0C, 8'h00, 8'hF0, 8'h0A, 8'h04},
    '{8'hAA, 8'h00, 8'h00, 8'h55, 8'hAA, 8'h55, 8'h00, 8'h55, 8'hAA}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic level_read();
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(3'd1, r); check("R1 dir", r, 8'hFF);
    peek(3'd2, r); check("R1 pu", r, 8'h00);
    peek(3'd3, r); check("R1 pd", r, 8'h00);
    peek(3'd4, r); check("R1 od", r, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pulls", pull_up | pull_dn, 8'h00);
    check("R1 chg", {7'd0, chg_event}, 8'h00);

    for (int v = 0; v < 6; v++) begin
      wr(3'd1, VECS[v].dir);
      wr(3'd4, VECS[v].od);
      wr(3'd0, VECS[v].lvl);
      wr(3'd2, VECS[v].pu);
      wr(3'd3, VECS[v].pd);
      peek(3'd1, r); check("R2 dir readback", r, VECS[v].dir);
      peek(3'd4, r); check("R2 od readback", r, VECS[v].od);
      peek(3'd2, r); check("R2 pu readback", r, VECS[v].pu);
      check("R3/R4/R5 pad_oe", pad_oe, VECS[v].e_oe);
      check("R3/R5 pad_out", pad_out, VECS[v].e_out);
      check("R7 pull_up", pull_up, VECS[v].e_pu);
      check("R7 pull_dn", pull_dn, VECS[v].e_pd);
      peek(3'd0, r); check("R6 level readback", r, VECS[v].lvl & ~VECS[v].dir);
    end

    // R6/R8: input sync latency and change flag
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h00);
    level_read();
    check("R9 flag clear", {7'd0, chg_event}, 8'h00);
    pad_in = 8'h5A;
    @(negedge clk); peek(3'd0, r); check("R6 one edge", r, 8'h00);
    @(negedge clk); peek(3'd0, r); check("R6 two edges", r, 8'h5A);
    check("R8 not yet", {7'd0, chg_event}, 8'h00);
    @(negedge clk); check("R8 flag rise", {7'd0, chg_event}, 8'h01);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R8 sticky", {7'd0, chg_event}, 8'h01);
    level_read();
    check("R9 read clears", {7'd0, chg_event}, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 stable after read", {7'd0, chg_event}, 8'h00);

    // R9: output-pin changes ignored
    wr(3'd1, 8'h00);
    pad_in = 8'hFF;
    repeat (5) @(negedge clk);
    check("R9 output pins ignored", {7'd0, chg_event}, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);

    // R10: unused addresses
    wr(3'd1, 8'h3C);
    wr(3'd6, 8'hC3);
    wr(3'd5, 8'h81);
    peek(3'd5, r); check("R10 read 5", r, 8'h00);
    peek(3'd7, r); check("R10 read 7", r, 8'h00);
    peek(3'd1, r); check("R10 dir untouched", r, 8'h3C);
    peek(3'd2, r); check("R10 pu untouched", r, 8'hAA & 8'h00 | 8'h55);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule